// File: doc/BRIEF.md
# Shared-Slave Bus Arbiter

This block lets several masters share one slave on a synchronous memory-style bus. On that bus a master raises chip select together with its address, write enable, byte selects and write data, and holds them until the slave acknowledges. The arbiter picks one of the requesting masters and forwards that master's request fields to the slave. It sends acknowledge and error back to that master alone.

A grant, once given, stays with its master for as long as the slave inserts wait states. It is released only in the cycle that carries the acknowledge. A master that keeps chip select high after its acknowledge can be served again in the very next cycle, so no dead cycle is lost. Read data comes back one cycle after the acknowledge. The arbiter therefore registers which master's read was acknowledged and steers the returned data to that master alone.

A parameter selects the arbitration policy. Mode 0 is fixed priority, mode 1 is round-robin, and mode 2 gives the masters in a high-group mask precedence over all others, with round-robin order applied within whichever group is served.

Top module: `shared_slave_arbiter`

## Requirements
- R1: When no master raises chip select and no transfer is held, slave chip select is low, and every master acknowledge and error output is low even if the slave drives acknowledge high.
- R2: In MODE 0 (fixed priority), the requesting master with the lowest index is granted when no transfer is held.
- R3: In MODE 1 (round-robin), a rotation pointer starts at index 0 after reset. After every acknowledged transfer it moves to the master after the one served, wrapping from NM-1 to 0. The grant goes to the first requesting master found from the pointer upward. Masters that are not requesting are skipped.
- R4: In MODE 2, a requesting master whose bit is set in HI_MASK always wins over masters whose bit is clear. Within the winning group, the round-robin order of R3 applies.
- R5: The slave receives the address, write enable, byte selects and write data of the granted master.
- R6: While the slave holds acknowledge low on an active transfer, the grant stays with the same master, even when other masters (including higher-priority ones) begin requesting.
- R7: A master that keeps chip select high after an acknowledge, with no competing requester, is acknowledged again in the following cycle, with no idle cycle in between.
- R8: Acknowledge and error reach only the granted master, and only while slave chip select is high. All other masters see both low.
- R9: One cycle after a read (write enable 0) is acknowledged, the slave read data appears on that master's read-data slot, and all other slots read zero. An acknowledged write does not move this routing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_cs | input | NM | Per-master chip select |
| m_we | input | NM | Per-master write enable (1 = write) |
| m_sel | input | NM*DW/8 | Per-master byte selects, master i in slice i |
| m_adr | input | NM*AW | Per-master address, master i in slice i |
| m_wdat | input | NM*DW | Per-master write data |
| m_ack | output | NM | Per-master acknowledge |
| m_err | output | NM | Per-master error |
| m_rdat | output | NM*DW | Per-master read data |
| s_cs | output | 1 | Slave chip select |
| s_we | output | 1 | Slave write enable |
| s_sel | output | DW/8 | Slave byte selects |
| s_adr | output | AW | Slave address |
| s_wdat | output | DW | Slave write data |
| s_ack | input | 1 | Slave acknowledge |
| s_err | input | 1 | Slave error, valid with acknowledge |
| s_rdat | input | DW | Slave read data, one cycle after a read acknowledge |

## Verification
The bench builds three copies with NM=4, AW=16 and DW=32, all sharing the same master and slave stimulus. The first copy uses MODE 0, the second MODE 1, and the third MODE 2 with HI_MASK=4'b1100. Driving all three with identical requests puts fixed-priority, rotating and grouped grant sequences side by side in the same cycles. The chosen master is visible on each copy's slave address. With four masters the rotation pointer wraps within a few transfers. The two-level mask splits the masters into two groups of two, so both the in-group rotation and the fall-back to the low group can be observed.

// File: rtl/shared_slave_arbiter.sv
module shared_slave_arbiter #(
  parameter int NM = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int MODE = 1,
  parameter logic [NM-1:0] HI_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NM-1:0]    m_cs,
  input  logic [NM-1:0]    m_we,
  input  logic [NM*DW/8-1:0] m_sel,
  input  logic [NM*AW-1:0] m_adr,
  input  logic [NM*DW-1:0] m_wdat,
  output logic [NM-1:0]    m_ack,
  output logic [NM-1:0]    m_err,
  output logic [NM*DW-1:0] m_rdat,
  output logic             s_cs,
  output logic             s_we,
  output logic [DW/8-1:0]  s_sel,
  output logic [AW-1:0]    s_adr,
  output logic [DW-1:0]    s_wdat,
  input  logic             s_ack,
  input  logic             s_err,
  input  logic [DW-1:0]    s_rdat
);
  localparam int BW = DW / 8;
  localparam int IW = (NM > 1) ? $clog2(NM) : 1;

  logic          hold_q;
  logic [IW-1:0] own_q, rr_q, rd_q, gnt;
  logic [IW:0]   win;
  logic [NM-1:0] hi_req;
  logic          done;

  function automatic logic [IW:0] pick(input logic [NM-1:0] req, input logic [IW-1:0] start);
    logic [IW:0] r;
    int j;
    r = '0;
    for (int k = NM - 1; k >= 0; k--) begin
      j = (int'(start) + k) % NM;
      if (req[j]) r = {1'b1, IW'(j)};
    end
    return r;
  endfunction

  assign hi_req = m_cs & HI_MASK;

  always_comb begin
    if (MODE == 0)
      win = pick(m_cs, '0);
    else if (MODE == 2 && |hi_req)
      win = pick(hi_req, rr_q);
    else
      win = pick(m_cs, rr_q);
  end

  assign gnt    = hold_q ? own_q : win[IW-1:0];
  assign s_cs   = hold_q ? m_cs[gnt] : win[IW];
  assign s_we   = m_we[gnt];
  assign s_sel  = m_sel[gnt*BW +: BW];
  assign s_adr  = m_adr[gnt*AW +: AW];
  assign s_wdat = m_wdat[gnt*DW +: DW];
  assign done   = s_cs & s_ack;

  for (genvar i = 0; i < NM; i++) begin : g_ret
    assign m_ack[i] = done && (gnt == IW'(i));
    assign m_err[i] = done && s_err && (gnt == IW'(i));
    assign m_rdat[i*DW +: DW] = (rd_q == IW'(i)) ? s_rdat : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      own_q  <= '0;
      rr_q   <= '0;
      rd_q   <= '0;
    end else begin
      hold_q <= s_cs & ~s_ack;
      own_q  <= gnt;
      if (done) rr_q <= (gnt == IW'(NM - 1)) ? '0 : gnt + 1'b1;
      if (done && !s_we) rd_q <= gnt;
    end
  end
endmodule

// File: rtl/arb_props.sv
module arb_props #(
  parameter int NM = 4,
  parameter int IW = 2,
  parameter int MODE = 1
) (
  input logic          clk,
  input logic          rst,
  input logic [NM-1:0] m_cs,
  input logic [NM-1:0] m_ack,
  input logic          s_cs,
  input logic          s_ack,
  input logic          s_we,
  input logic          hold_q,
  input logic [IW-1:0] gnt,
  input logic [IW-1:0] rd_q
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !s_cs |-> (m_ack == '0));
  // R8
  one_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_ack));
  // R8
  ack_reaches_chk: assert property (@(posedge clk) disable iff (rst)
    (s_cs && s_ack) |-> ($countones(m_ack) == 1));
  // R6
  grant_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (s_cs && !s_ack) |=> (gnt == $past(gnt)));
  // R9
  read_route_chk: assert property (@(posedge clk) disable iff (rst)
    (s_cs && s_ack && !s_we) |=> (rd_q == $past(gnt)));
  // R2
  prio_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (MODE == 0 && !hold_q && m_cs[0]) |-> (gnt == '0));
endmodule

bind shared_slave_arbiter arb_props #(.NM(NM), .IW(IW), .MODE(MODE)) u_props (
  .clk(clk), .rst(rst), .m_cs(m_cs), .m_ack(m_ack), .s_cs(s_cs), .s_ack(s_ack),
  .s_we(s_we), .hold_q(hold_q), .gnt(gnt), .rd_q(rd_q)
);

// File: tb/shared_slave_arbiter_tb.sv
module shared_slave_arbiter_tb;
  localparam int NM = 4, AW = 16, DW = 32, BW = DW / 8;

  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic [NM-1:0] m_cs = '0, m_we = '0;
  logic [NM*BW-1:0] m_sel;
  logic [NM*AW-1:0] m_adr;
  logic [NM*DW-1:0] m_wdat;
  logic s_ack = 0, s_err = 0;
  logic [DW-1:0] s_rdat = '0;

  logic [NM-1:0] ack0, err0, ack1, err1, ack2, err2;
  logic [NM*DW-1:0] rd0, rd1, rd2;
  logic cs0, we0, cs1, we1, cs2, we2;
  logic [BW-1:0] sel0, sel1, sel2;
  logic [AW-1:0] adr0, adr1, adr2;
  logic [DW-1:0] wd0, wd1, wd2;

  shared_slave_arbiter #(.NM(NM), .AW(AW), .DW(DW), .MODE(0)) u_dut (
    .clk(clk), .rst(rst), .m_cs(m_cs), .m_we(m_we), .m_sel(m_sel), .m_adr(m_adr),
    .m_wdat(m_wdat), .m_ack(ack0), .m_err(err0), .m_rdat(rd0), .s_cs(cs0), .s_we(we0),
    .s_sel(sel0), .s_adr(adr0), .s_wdat(wd0), .s_ack(s_ack), .s_err(s_err), .s_rdat(s_rdat));
  shared_slave_arbiter #(.NM(NM), .AW(AW), .DW(DW), .MODE(1)) u_rr (
    .clk(clk), .rst(rst), .m_cs(m_cs), .m_we(m_we), .m_sel(m_sel), .m_adr(m_adr),
    .m_wdat(m_wdat), .m_ack(ack1), .m_err(err1), .m_rdat(rd1), .s_cs(cs1), .s_we(we1),
    .s_sel(sel1), .s_adr(adr1), .s_wdat(wd1), .s_ack(s_ack), .s_err(s_err), .s_rdat(s_rdat));
  shared_slave_arbiter #(.NM(NM), .AW(AW), .DW(DW), .MODE(2), .HI_MASK(4'b1100)) u_mix (
    .clk(clk), .rst(rst), .m_cs(m_cs), .m_we(m_we), .m_sel(m_sel), .m_adr(m_adr),
    .m_wdat(m_wdat), .m_ack(ack2), .m_err(err2), .m_rdat(rd2), .s_cs(cs2), .s_we(we2),
    .s_sel(sel2), .s_adr(adr2), .s_wdat(wd2), .s_ack(s_ack), .s_err(s_err), .s_rdat(s_rdat));

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] a(input int i);
    return 32'(16'h0A00 + i);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1; m_cs = '0; m_we = '1; s_ack = 0; s_err = 0; s_rdat = '0;
    for (int i = 0; i < NM; i++) begin
      m_adr[i*AW +: AW]  = 16'h0A00 + 16'(i);
      m_wdat[i*DW +: DW] = 32'hD000_0000 + 32'(i);
      m_sel[i*BW +: BW]  = 4'(1 << i);
    end
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic cyc(input logic [NM-1:0] cs, input logic ack);
    @(negedge clk);
    m_cs = cs; s_ack = ack;
    #2;
  endtask

  task automatic t_idle();
    do_reset();
    cyc(4'b0000, 1'b1);
    chk("R1 s_cs idle", 32'(cs0), 0);
    chk("R1 ack idle", 32'(ack0), 0);
    s_err = 1; #1;
    chk("R1 err idle", 32'(err0), 0);
    s_err = 0;
  endtask

  task automatic t_sched();
    do_reset();
    for (int c = 0; c < 5; c++) begin
      cyc(4'b1111, 1'b1);
      chk("R2 prio grant", 32'(adr0), a(0));
      chk("R3 rr grant", 32'(adr1), a(c % 4));
      chk("R4 hi group rotation", 32'(adr2), a(2 + (c % 2)));
    end
    do_reset();
    for (int c = 0; c < 3; c++) begin
      cyc(4'b1010, 1'b1);
      chk("R3 rr skip", 32'(adr1), a((c % 2) ? 3 : 1));
    end
    do_reset();
    for (int c = 0; c < 3; c++) begin
      cyc(4'b0011, 1'b1);
      chk("R4 low group rotation", 32'(adr2), a(c % 2));
    end
  endtask

  task automatic t_fwd();
    do_reset();
    m_we[1] = 0; m_sel[1*BW +: BW] = 4'b0011; m_wdat[1*DW +: DW] = 32'h1357_9BDF;
    cyc(4'b0110, 1'b0);
    chk("R5 adr", 32'(adr0), a(1));
    chk("R5 we", 32'(we0), 0);
    chk("R5 sel", 32'(sel0), 32'h3);
    chk("R5 wdat", wd0, 32'h1357_9BDF);
  endtask

  task automatic t_lock();
    do_reset();
    cyc(4'b0010, 1'b0);
    cyc(4'b0011, 1'b0);
    chk("R6 held grant", 32'(adr0), a(1));
    chk("R6 no ack while stalled", 32'(ack0), 0);
    cyc(4'b0011, 1'b1);
    chk("R6 ack to holder", 32'(ack0), 32'b0010);
    cyc(4'b0001, 1'b1);
    chk("R2 released to m0", 32'(ack0), 32'b0001);
  endtask

  task automatic t_b2b();
    do_reset();
    for (int c = 0; c < 3; c++) begin
      cyc(4'b0100, 1'b1);
      chk("R7 back-to-back ack", 32'(ack0), 32'b0100);
      chk("R7 back-to-back rr", 32'(ack1), 32'b0100);
    end
  endtask

  task automatic t_err();
    do_reset();
    s_err = 1;
    cyc(4'b1001, 1'b1);
    chk("R8 err to granted", 32'(err0), 32'b0001);
    chk("R8 ack to granted", 32'(ack0), 32'b0001);
    s_err = 0;
    cyc(4'b1000, 1'b0);
    chk("R8 no ack stalled", 32'(ack0), 0);
  endtask

  task automatic t_read();
    do_reset();
    m_we[2] = 0; m_we[3] = 0;
    cyc(4'b0100, 1'b1);
    chk("R9 read ack", 32'(ack0), 32'b0100);
    cyc(4'b0010, 1'b1);
    s_rdat = 32'h1234_5678; #1;
    chk("R9 data to reader", rd0[2*DW +: DW], 32'h1234_5678);
    chk("R9 other slot zero", rd0[1*DW +: DW], 0);
    cyc(4'b1000, 1'b1);
    s_rdat = 32'hCAFE_0001; #1;
    chk("R9 write keeps routing", rd0[2*DW +: DW], 32'hCAFE_0001);
    cyc(4'b0000, 1'b0);
    s_rdat = 32'h0BAD_F00D; #1;
    chk("R9 new reader slot", rd0[3*DW +: DW], 32'h0BAD_F00D);
    chk("R9 old reader cleared", rd0[2*DW +: DW], 0);
  endtask

  initial begin
    t_idle();
    t_sched();
    t_fwd();
    t_lock();
    t_b2b();
    t_err();
    t_read();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule